// File: doc/BRIEF.md
# Laser Transmitter Safety Supervisor

This block is the digital supervisor that sits beside the bias and modulation current sources of an optical transmitter. It takes pre-compared flags from the analog monitors and a transmit-disable level, and it decides when the two current sources may run. After reset, a start-up window holds the drivers off and masks every alarm while the analog loops calibrate. After that window the supervisor enters normal operation, and any monitor flag that persists long enough sets a latched fault.

The fault turns both drivers off unless an external override keeps them running. The fault can be cleared only by holding transmit-disable high for a minimum time and then releasing it. The clear restarts the start-up window. A ready flag reports normal operation with no fault pending.

All timing comes from a shared tick. The tick divides the clock by `TICK_DIV`, so a 1 µs tick gives a 25 ms window with `MASK_TICKS` = 25000. One of the alarm sources, the extinction-reference short, only counts when the mode input selects voltage setpoint.

Top module: `laser_tx_supervisor`

## Requirements
- R1: While `txDisable` is high, `biasEn` and `modEn` are both low no later than 4 clock cycles after it rises. During reset the disable path reads as high, so the drivers stay off.
- R2: After reset, `ready`, `biasEn`, `modEn` and `failFlag` stay low for a mask window of `MASK_TICKS` ticks. An alarm flag that is high only inside this window and drops before it ends never sets `failFlag`.
- R3: `failFlag` is active high and latched. Once set, it stays set after the offending flag returns low, until a valid clear (R4).
- R4: A fault clears only when `txDisable` has been high for at least `HOLD_TICKS` ticks and then goes low. A shorter high pulse leaves `failFlag` set.
- R5: After the window, `biasMonHigh` (bias-monitor voltage above its trip point) held high sets `failFlag` and drops `biasEn`/`modEn`.
- R6: After the window, either `pdSetHigh` or `pdSetLow` (photodiode setpoint node above its upper or below its lower threshold) held high sets `failFlag`.
- R7: `erRefShort` sets `failFlag` only when `modeVoltage` = 1 (voltage setpoint). With `modeVoltage` = 0 (resistor setpoint) the flag is ignored, and `failFlag` stays 0 with the drivers on.
- R8: After the window, `biasNodeLow` (bias-current node shorted low) held high sets `failFlag`.
- R9: With `failOverride` = 1 and a latched fault, `biasEn` and `modEn` are high while `failFlag` stays 1. With `failOverride` = 0, a fault holds both enables low.
- R10: A flag must stay high across `FILT_TICKS` ticks before it counts. A flag high for fewer than `TICK_DIV` cycles never sets `failFlag`. A qualifying flag sets `failFlag` within `FILT_TICKS`+2 ticks plus 4 cycles.
- R11: A valid clear restarts the mask window, with `ready` and the enables low until the window ends. At the end of the window `ready` rises if no alarm is qualified. If an alarm is still qualified at that point, `failFlag` sets again instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txDisable | input | 1 | Transmit disable level, high = drivers off; also the fault-clear pulse |
| modeVoltage | input | 1 | 1 = voltage setpoint mode, 0 = resistor setpoint mode |
| failOverride | input | 1 | 1 = keep drivers on while a fault is flagged |
| biasMonHigh | input | 1 | Bias-monitor voltage above trip point |
| pdSetHigh | input | 1 | Photodiode setpoint node above upper threshold |
| pdSetLow | input | 1 | Photodiode setpoint node below lower threshold |
| erRefShort | input | 1 | Extinction-reference node shorted to supply |
| biasNodeLow | input | 1 | Bias-current node shorted low |
| biasEn | output | 1 | Bias current source enable |
| modEn | output | 1 | Modulation current source enable |
| failFlag | output | 1 | Latched fault, active high |
| ready | output | 1 | Normal operation, window expired, no fault |

## Verification
The bench builds the block with `TICK_DIV` = 4, `MASK_TICKS` = 40, `HOLD_TICKS` = 5 and `FILT_TICKS` = 3. With these values the 25 ms window shrinks to 160 cycles, the minimum disable hold to 20 cycles, and a flag must persist about 12 cycles before it counts. This lets one run reach the following cases in a few thousand cycles:
- every alarm source, with a fault, a latch and a clear for each;
- short and long clear pulses;
- alarms that arrive during the window;
- an alarm still present when a restarted window expires.

// File: rtl/laser_sup_pkg.sv
package laser_sup_pkg;
  localparam int ALARM_N    = 5;
  localparam int AL_BIASMON = 0;
  localparam int AL_PDHIGH  = 1;
  localparam int AL_PDLOW   = 2;
  localparam int AL_ERSHORT = 3;
  localparam int AL_BIASLOW = 4;

  typedef enum logic [1:0] {ST_INIT, ST_RUN, ST_FAULT} supStateT;

  typedef struct packed {
    logic startMask;
  } ctrlStrobeT;

  typedef struct packed {
    logic disHigh;
    logic disFell;
    logic holdMet;
    logic maskDone;
    logic alarmAny;
    logic overrideOn;
  } dpStatusT;
endpackage

// File: rtl/laser_sup_sync.sv
module laser_sup_sync #(
  parameter int   W       = 1,
  parameter logic RST_BIT = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= {W{RST_BIT}};
      syncOut <= {W{RST_BIT}};
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/laser_sup_filter.sv
module laser_sup_filter #(
  parameter int FILT_TICKS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic rawIn,
  output logic qualOut
);
  localparam int CW = $clog2(FILT_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(FILT_TICKS);

  logic [CW-1:0] persistCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             persistCnt <= '0;
    else if (!rawIn)                       persistCnt <= '0;
    else if (tick && persistCnt != FULL)   persistCnt <= persistCnt + 1'b1;
  end

  assign qualOut = rawIn && (persistCnt == FULL);

  // R10: a qualified flag implies the raw flag was already present a cycle earlier
  a_r10_no_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    qualOut |-> $past(rawIn));
endmodule

// File: rtl/laser_sup_datapath.sv
module laser_sup_datapath
  import laser_sup_pkg::*;
#(
  parameter int TICK_DIV   = 100,
  parameter int MASK_TICKS = 25000,
  parameter int HOLD_TICKS = 6,
  parameter int FILT_TICKS = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txDisableIn,
  input  logic               modeVoltageIn,
  input  logic               overrideIn,
  input  logic [ALARM_N-1:0] alarmIn,
  input  ctrlStrobeT         strobe,
  output dpStatusT           status
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int MW = $clog2(MASK_TICKS + 1);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_DIV - 1);
  localparam logic [MW-1:0] MASK_END  = MW'(MASK_TICKS);
  localparam logic [HW-1:0] HOLD_END  = HW'(HOLD_TICKS);
  localparam int SW = ALARM_N + 2;

  logic [TW-1:0] divCnt;
  logic          tick;
  logic          disSync;
  logic          disPrev;
  logic [SW-1:0] miscSync;
  logic [ALARM_N-1:0] alarmSync, alarmGated, alarmQual;
  logic          modeSync, overrideSync;
  logic [MW-1:0] maskCnt;
  logic [HW-1:0] holdCnt;
  logic          maskDone, holdMet;

  // shared time base
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      divCnt <= '0;
    else if (tick)  divCnt <= '0;
    else            divCnt <= divCnt + 1'b1;
  end
  assign tick = (divCnt == TICK_LAST);

  // disable path resets to "disabled" (R1)
  laser_sup_sync #(.W(1), .RST_BIT(1'b1)) u_disSync (
    .clk(clk), .rstN(rstN), .asyncIn(txDisableIn), .syncOut(disSync));

  laser_sup_sync #(.W(SW), .RST_BIT(1'b0)) u_miscSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({overrideIn, modeVoltageIn, alarmIn}),
    .syncOut(miscSync));

  assign alarmSync    = miscSync[ALARM_N-1:0];
  assign modeSync     = miscSync[ALARM_N];
  assign overrideSync = miscSync[ALARM_N+1];

  // R7: extinction-reference short only meaningful in voltage setpoint mode
  always_comb begin
    alarmGated = alarmSync;
    if (!modeSync) alarmGated[AL_ERSHORT] = 1'b0;
  end

  for (genvar g = 0; g < ALARM_N; g++) begin : g_filt
    laser_sup_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
      .clk(clk), .rstN(rstN), .tick(tick),
      .rawIn(alarmGated[g]), .qualOut(alarmQual[g]));
  end

  // start-up mask window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     maskCnt <= '0;
    else if (strobe.startMask)     maskCnt <= '0;
    else if (tick && !maskDone)    maskCnt <= maskCnt + 1'b1;
  end
  assign maskDone = (maskCnt == MASK_END);

  // minimum hold time of the disable level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
      disPrev <= 1'b1;
    end else begin
      disPrev <= disSync;
      if (!disSync)               holdCnt <= '0;
      else if (tick && !holdMet)  holdCnt <= holdCnt + 1'b1;
    end
  end
  assign holdMet = (holdCnt == HOLD_END);

  assign status.disHigh    = disSync;
  assign status.disFell    = disPrev && !disSync;
  assign status.holdMet    = holdMet;
  assign status.maskDone   = maskDone;
  assign status.alarmAny   = |alarmQual;
  assign status.overrideOn = overrideSync;

  // R2: a restart strobe always reopens the window
  a_r2_window_restart: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startMask |=> !maskDone);

  // R4: hold qualification never survives a low disable level
  a_r4_hold_needs_high: assert property (@(posedge clk) disable iff (!rstN)
    holdMet |-> $past(disSync));
endmodule

// File: rtl/laser_sup_ctrl.sv
module laser_sup_ctrl
  import laser_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatusT   sts,
  output ctrlStrobeT strobe,
  output logic       biasEn,
  output logic       modEn,
  output logic       failFlag,
  output logic       ready
);
  supStateT state, nextState;
  logic     driveOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_INIT;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_INIT:  if (sts.maskDone) nextState = sts.alarmAny ? ST_FAULT : ST_RUN;
      ST_RUN:   if (sts.alarmAny) nextState = ST_FAULT;
      ST_FAULT: if (sts.disFell && sts.holdMet) nextState = ST_INIT;
      default:  nextState = ST_INIT;
    endcase
  end

  assign strobe.startMask = (state == ST_FAULT) && (nextState == ST_INIT);

  assign driveOk  = !sts.disHigh &&
                    ((state == ST_RUN) || ((state == ST_FAULT) && sts.overrideOn));
  assign biasEn   = driveOk;
  assign modEn    = driveOk;
  assign failFlag = (state == ST_FAULT);
  assign ready    = (state == ST_RUN);

  // R3: the fault persists unless a qualified clear is seen
  a_r3_fault_latched: assert property (@(posedge clk) disable iff (!rstN)
    failFlag && !(sts.disFell && sts.holdMet) |=> failFlag);

  // R4: a fault only drops after the hold time was met
  a_r4_clear_after_hold: assert property (@(posedge clk) disable iff (!rstN)
    $fell(failFlag) |-> $past(sts.holdMet));

  // R9: without override a fault keeps both drivers off
  a_r9_fault_drivers_off: assert property (@(posedge clk) disable iff (!rstN)
    failFlag && !sts.overrideOn |-> !biasEn && !modEn);

  // R11: ready only once the mask window has run out
  a_r11_ready_after_window: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> sts.maskDone);
endmodule

// File: rtl/laser_tx_supervisor.sv
module laser_tx_supervisor
  import laser_sup_pkg::*;
#(
  parameter int TICK_DIV   = 100,
  parameter int MASK_TICKS = 25000,
  parameter int HOLD_TICKS = 6,
  parameter int FILT_TICKS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic txDisable,
  input  logic modeVoltage,
  input  logic failOverride,
  input  logic biasMonHigh,
  input  logic pdSetHigh,
  input  logic pdSetLow,
  input  logic erRefShort,
  input  logic biasNodeLow,
  output logic biasEn,
  output logic modEn,
  output logic failFlag,
  output logic ready
);
  ctrlStrobeT         strobe;
  dpStatusT           status;
  logic [ALARM_N-1:0] alarmVec;

  always_comb begin
    alarmVec             = '0;
    alarmVec[AL_BIASMON] = biasMonHigh;
    alarmVec[AL_PDHIGH]  = pdSetHigh;
    alarmVec[AL_PDLOW]   = pdSetLow;
    alarmVec[AL_ERSHORT] = erRefShort;
    alarmVec[AL_BIASLOW] = biasNodeLow;
  end

  laser_sup_datapath #(
    .TICK_DIV(TICK_DIV), .MASK_TICKS(MASK_TICKS),
    .HOLD_TICKS(HOLD_TICKS), .FILT_TICKS(FILT_TICKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .txDisableIn(txDisable),
    .modeVoltageIn(modeVoltage), .overrideIn(failOverride),
    .alarmIn(alarmVec), .strobe(strobe), .status(status));

  laser_sup_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sts(status), .strobe(strobe),
    .biasEn(biasEn), .modEn(modEn), .failFlag(failFlag), .ready(ready));

  // R1: a disable level seen over three edges has shut both drivers
  a_r1_disable_shutdown: assert property (@(posedge clk) disable iff (!rstN)
    txDisable && $past(txDisable) && $past(txDisable, 2) |-> !biasEn && !modEn);
endmodule

// File: tb/sim_laser_tx_supervisor.sv
module sim_laser_tx_supervisor;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txDisable = 1'b0, modeVoltage = 1'b1, failOverride = 1'b0;
  logic [4:0] alarmDrv = '0;
  logic biasEn, modEn, failFlag, ready;
  int   tests = 0, failed = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  laser_tx_supervisor #(.TICK_DIV(4), .MASK_TICKS(40), .HOLD_TICKS(5), .FILT_TICKS(3)) u0 (
    .clk(clk), .rstN(rstN), .txDisable(txDisable), .modeVoltage(modeVoltage),
    .failOverride(failOverride), .biasMonHigh(alarmDrv[0]), .pdSetHigh(alarmDrv[1]),
    .pdSetLow(alarmDrv[2]), .erRefShort(alarmDrv[3]), .biasNodeLow(alarmDrv[4]),
    .biasEn(biasEn), .modEn(modEn), .failFlag(failFlag), .ready(ready));

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic clearFault();
    txDisable = 1'b1; waitCyc(40);
    txDisable = 1'b0; waitCyc(6);
  endtask

  task automatic t_reset();
    rstN = 1'b0; waitCyc(3); rstN = 1'b1;
    waitCyc(5);
    check("R2", "ready in window", ready, 1'b0);
    check("R2", "biasEn in window", biasEn, 1'b0);
    check("R2", "failFlag in window", failFlag, 1'b0);
    alarmDrv[0] = 1'b1; waitCyc(50); alarmDrv[0] = 1'b0;
    waitCyc(80);
    check("R2", "ready before window end", ready, 1'b0);
    waitCyc(70);
    check("R2", "ready after window", ready, 1'b1);
    check("R2", "masked alarm no fault", failFlag, 1'b0);
    check("R2", "biasEn after window", biasEn, 1'b1);
    check("R2", "modEn after window", modEn, 1'b1);
  endtask

  task automatic t_disable();
    txDisable = 1'b1; waitCyc(4);
    check("R1", "biasEn off", biasEn, 1'b0);
    check("R1", "modEn off", modEn, 1'b0);
    waitCyc(6); txDisable = 1'b0; waitCyc(4);
    check("R1", "biasEn back", biasEn, 1'b1);
    check("R1", "no fault from disable", failFlag, 1'b0);
  endtask

  task automatic t_source(int idx, string req);
    alarmDrv[idx] = 1'b1; waitCyc(30);
    check(req, "fault set", failFlag, 1'b1);
    check(req, "biasEn dropped", biasEn, 1'b0);
    check(req, "modEn dropped", modEn, 1'b0);
    waitCyc(10); alarmDrv[idx] = 1'b0; waitCyc(20);
    check("R3", "fault latched", failFlag, 1'b1);
    clearFault();
    check("R4", "fault cleared", failFlag, 1'b0);
    check("R11", "ready low after clear", ready, 1'b0);
    check("R11", "biasEn low after clear", biasEn, 1'b0);
    waitCyc(200);
    check("R11", "ready after restarted window", ready, 1'b1);
    check("R11", "biasEn after restarted window", biasEn, 1'b1);
  endtask

  task automatic t_shortPulse();
    alarmDrv[0] = 1'b1; waitCyc(30); alarmDrv[0] = 1'b0;
    txDisable = 1'b1; waitCyc(8); txDisable = 1'b0; waitCyc(10);
    check("R4", "short pulse keeps fault", failFlag, 1'b1);
    clearFault();
    check("R4", "long pulse clears", failFlag, 1'b0);
    waitCyc(200);
  endtask

  task automatic t_resistorMode();
    modeVoltage = 1'b0; waitCyc(5);
    alarmDrv[3] = 1'b1; waitCyc(40);
    check("R7", "er short ignored", failFlag, 1'b0);
    check("R7", "biasEn kept", biasEn, 1'b1);
    alarmDrv[3] = 1'b0; modeVoltage = 1'b1; waitCyc(5);
  endtask

  task automatic t_glitch();
    for (int k = 0; k < 4; k++) begin
      alarmDrv[4] = 1'b1; waitCyc(2); alarmDrv[4] = 1'b0; waitCyc(10);
    end
    waitCyc(20);
    check("R10", "glitches rejected", failFlag, 1'b0);
    check("R10", "ready kept", ready, 1'b1);
  endtask

  task automatic t_override();
    alarmDrv[2] = 1'b1; waitCyc(30); alarmDrv[2] = 1'b0;
    failOverride = 1'b1; waitCyc(4);
    check("R9", "override biasEn", biasEn, 1'b1);
    check("R9", "override modEn", modEn, 1'b1);
    check("R9", "override fault flagged", failFlag, 1'b1);
    failOverride = 1'b0; waitCyc(4);
    check("R9", "no override biasEn", biasEn, 1'b0);
    clearFault(); waitCyc(200);
  endtask

  task automatic t_persist();
    alarmDrv[1] = 1'b1; waitCyc(30);
    check("R6", "pd high fault", failFlag, 1'b1);
    clearFault();
    check("R11", "clear with alarm present", failFlag, 1'b0);
    waitCyc(200);
    check("R11", "persisting alarm refaults", failFlag, 1'b1);
    check("R11", "ready stays low", ready, 1'b0);
    alarmDrv[1] = 1'b0; waitCyc(5);
    clearFault(); waitCyc(200);
    check("R11", "ready after final clear", ready, 1'b1);
  endtask

  initial begin
    t_reset();
    t_disable();
    t_source(0, "R5");
    t_source(1, "R6");
    t_source(2, "R6");
    t_source(3, "R7");
    t_source(4, "R8");
    t_shortPulse();
    t_resistorMode();
    t_glitch();
    t_override();
    t_persist();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end
endmodule